// File: doc/BRIEF.md
# Packed Halfword Shift-and-Add Unit

This block works on a word that holds several signed 16-bit lanes. In each lane it scales the first operand by a power of two and adds the second operand. The scaling is a shift of 1, 2 or 3 places. A left shift multiplies by 2, 4 or 8, and a right shift divides by 2, 4 or 8. A short chain of these operations forms a multiply by a constant, whole or fractional, without a multiplier. Every lane result is clamped to the signed 16-bit range. No lane ever passes bits or carries to its neighbour.

The lane count is a parameter: 2 lanes for a 32-bit word, 4 lanes for a 64-bit word. An operation is presented with a one-cycle strobe. Its result appears in an output register on the next cycle, with a matching valid flag.

Top module: `pshadd_unit`

## Requirements
- R1: With `in_dir` = 0 (left), every lane computes sat(a·2^k + b). Here a and b are that lane's signed 16-bit fields from `in_a` and `in_b`, and k is the binary value of `in_amt`.
- R2: With `in_dir` = 1 (right), every lane computes sat(floor(a / 2^k) + b). This is an arithmetic, sign-extending shift. Bits shifted out are dropped without rounding.
- R3: Each lane result is clamped to the range 32767 (0x7FFF) to -32768 (0x8000). This includes results where the shift alone already exceeds 16 bits, for example 0x5000 shifted left by 3.
- R4: Lane i occupies bits [16i+15:16i] of every packed port. The result of a lane depends only on the same lane of the operands. A left shift never moves bits into the next higher lane, and a right shift never moves bits down from it.
- R5: An `in_amt` value of 0 is illegal. It is handled exactly like `in_amt` = 1.
- R6: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high, and low otherwise. `out_data` carries that operation's result in the same cycle.
- R7: While `in_valid` is low, `out_data` keeps its previous value, whatever the other inputs do.
- R8: After reset, `out_valid` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 16·LANES | Packed operands that are shifted |
| in_b | input | 16·LANES | Packed addends |
| in_dir | input | 1 | 0 = shift left, 1 = shift right |
| in_amt | input | 2 | Shift amount, 1 to 3 (0 is treated as 1) |
| out_valid | output | 1 | Result valid |
| out_data | output | 16·LANES | Packed saturated results |

## Verification
The bench targets these corner cases:
- **Left-shift overflow before the add.** It drives operands whose left shift alone leaves the 16-bit range, including 0x5000 shifted by 3 with a large negative addend. A preshifter that keeps only 16 or 17 bits would wrap, and would return a small or wrongly signed value instead of 32767.
- **Right shift of negative odd values.** It checks that -5 shifted right by 1 gives -3, not -2. A logical shift or a shift that rounds toward zero gives the wrong result.
- **Lane isolation.** An all-ones lane sits above a lane being shifted right, and a saturating lane sits beside ordinary ones. Any leak of carries or shifted bits across a lane boundary corrupts the neighbouring lane.
- **Illegal amount and timing.** An amount of 0 must give the same result as 1. Back-to-back strobes and idle cycles check the one-cycle latency and the hold behaviour.

// File: rtl/pshadd_pkg.sv
package pshadd_pkg;

   localparam int LANE_W = 16;
   localparam int AMT_W  = 2;

   typedef enum logic {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } shdir_e;

   // The encoding 0 is illegal and is mapped onto the smallest legal shift.
   function automatic logic [AMT_W-1:0] legal_amt(input logic [AMT_W-1:0] raw);
      return (raw == '0) ? AMT_W'(1) : raw;
   endfunction

endpackage

// File: rtl/pshadd_preshift.sv
module pshadd_preshift
   import pshadd_pkg::*;
#(
   parameter int DW   = 16,
   parameter int KW   = 2,
   localparam int XW  = DW + (1 << KW) - 1
) (
   input  logic [DW-1:0]        opnd,
   input  logic                 dir,
   input  logic [KW-1:0]        amt,
   output logic signed [XW-1:0] shifted
);

   logic signed [XW-1:0] widened;

   always_comb begin
      widened = {{(XW-DW){opnd[DW-1]}}, opnd};
      if (shdir_e'(dir) == DIR_RIGHT)
         shifted = widened >>> amt;
      else
         shifted = widened <<< amt;
   end

endmodule

// File: rtl/pshadd_satadd.sv
module pshadd_satadd #(
   parameter int DW  = 16,
   parameter int XW  = 19,
   localparam int SW = XW + 1
) (
   input  logic signed [XW-1:0] lhs,
   input  logic [DW-1:0]        rhs,
   output logic [DW-1:0]        res
);

   localparam logic signed [SW-1:0] SAT_HI = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
   localparam logic signed [SW-1:0] SAT_LO = -SAT_HI - SW'(1);

   logic signed [SW-1:0] total;

   always_comb begin
      total = {lhs[XW-1], lhs} + {{(SW-DW){rhs[DW-1]}}, rhs};
      if (total > SAT_HI)
         res = {1'b0, {(DW-1){1'b1}}};
      else if (total < SAT_LO)
         res = {1'b1, {(DW-1){1'b0}}};
      else
         res = total[DW-1:0];
   end

endmodule

// File: rtl/pshadd_lane.sv
module pshadd_lane #(
   parameter int DW   = 16,
   parameter int KW   = 2,
   localparam int XW  = DW + (1 << KW) - 1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          dir,
   input  logic [KW-1:0] amt,
   output logic [DW-1:0] y
);

   logic signed [XW-1:0] scaled;

   pshadd_preshift #(.DW(DW), .KW(KW)) u_shift (
      .opnd    (a),
      .dir     (dir),
      .amt     (amt),
      .shifted (scaled)
   );

   pshadd_satadd #(.DW(DW), .XW(XW)) u_sat (
      .lhs (scaled),
      .rhs (b),
      .res (y)
   );

endmodule

// File: rtl/pshadd_unit.sv
module pshadd_unit
   import pshadd_pkg::*;
#(
   parameter int LANES = 4,
   localparam int W    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_a,
   input  logic [W-1:0]     in_b,
   input  logic             in_dir,
   input  logic [AMT_W-1:0] in_amt,
   output logic             out_valid,
   output logic [W-1:0]     out_data
);

   generate
      if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
         $error("pshadd_unit: LANES must be 2 or 4");
      end
   endgenerate

   logic [AMT_W-1:0] amt_eff;
   logic [W-1:0]     lane_res;

   assign amt_eff = legal_amt(in_amt);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pshadd_lane #(.DW(LANE_W), .KW(AMT_W)) u_lane (
         .a   (in_a[i*LANE_W +: LANE_W]),
         .b   (in_b[i*LANE_W +: LANE_W]),
         .dir (in_dir),
         .amt (amt_eff),
         .y   (lane_res[i*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_data <= lane_res;
      end
   end

endmodule

// File: rtl/pshadd_chk.sv
module pshadd_chk #(
   parameter int LANES = 4,
   localparam int LW   = 16,
   localparam int W    = LANES * LW
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [W-1:0] in_a,
   input logic [W-1:0] in_b,
   input logic         in_dir,
   input logic         out_valid,
   input logic [W-1:0] out_data
);

   // R6
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R6
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R7
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      // R3
      pos_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_dir && !in_a[i*LW+LW-1] && !in_b[i*LW+LW-1])
         |=> !out_data[i*LW+LW-1]);

      // R3
      neg_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_dir && in_a[i*LW+LW-1] && in_b[i*LW+LW-1])
         |=> out_data[i*LW+LW-1]);

      // R2
      right_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_dir && in_b[i*LW +: LW] == '0)
         |=> (out_data[i*LW+LW-1] == $past(in_a[i*LW+LW-1])));
   end

endmodule

bind pshadd_unit pshadd_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .in_dir    (in_dir),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_pshadd_unit.sv
module sim_pshadd_unit;

   localparam int LN = 4;
   localparam int W  = LN * 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_a = '0;
   logic [W-1:0] in_b = '0;
   logic         in_dir = 1'b0;
   logic [1:0]   in_amt = 2'd1;
   logic         out_valid;
   logic [W-1:0] out_data;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pshadd_unit #(.LANES(LN)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_dir(in_dir), .in_amt(in_amt), .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                            input bit dir, input int k);
      int s;
      int sa;
      sa = int'($signed(a));
      if (!dir) s = sa * (1 << k);
      else      s = sa >>> k;
      s = s + int'($signed(b));
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return s[15:0];
   endfunction

   function automatic logic [W-1:0] ref_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input bit dir, input logic [1:0] amt);
      logic [W-1:0] r;
      int k;
      k = (amt == 2'd0) ? 1 : int'(amt);
      for (int i = 0; i < LN; i++)
         r[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16], dir, k);
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit dir, input logic [1:0] amt);
      if (amt == 2'd0) $display("note: illegal shift amount 0 driven");
      in_valid = 1'b1; in_a = a; in_b = b; in_dir = dir; in_amt = amt;
   endtask

   // one operation: drive, wait one edge, check
   task automatic one_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit dir, input logic [1:0] amt);
      @(negedge clk);
      launch(a, b, dir, amt);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({req, " valid"}, out_valid, 1'b1);
      check(req, out_data, ref_vec(a, b, dir, amt));
   endtask

   task automatic t_reset;
      // R8
      check_bit("R8 valid", out_valid, 1'b0);
      check("R8 data", out_data, '0);
   endtask

   task automatic t_left;
      // R1: lanes 3,-2,0x0100,0x1234 with assorted addends
      one_op("R1 k2", {16'h1234, 16'h0100, 16'hFFFE, 16'h0003},
                      {16'h0001, 16'hFFFF, 16'h0007, 16'h0005}, 1'b0, 2'd2);
      one_op("R1 k1", {16'hFF00, 16'h0010, 16'h0200, 16'h7000},
                      {16'h0000, 16'hFFF0, 16'h0100, 16'h8000}, 1'b0, 2'd1);
      one_op("R1 k3", {16'h0123, 16'hFC00, 16'h0001, 16'hFFFF},
                      {16'h1111, 16'h0003, 16'hFFF8, 16'h0008}, 1'b0, 2'd3);
      check("R1 literal", out_data[15:0], 16'h0000);
   endtask

   task automatic t_right;
      // R2: -5 >> 1 must be -3 (floor), lane0
      one_op("R2 k1", {16'h7FFF, 16'h8001, 16'h0007, 16'hFFFB},
                      {16'h0000, 16'h0000, 16'h0001, 16'h0000}, 1'b1, 2'd1);
      check("R2 floor", out_data[15:0], 16'hFFFD);
      one_op("R2 k3", {16'hFFF9, 16'h4000, 16'h8000, 16'h0017},
                      {16'h0002, 16'hFF00, 16'h0010, 16'h0000}, 1'b1, 2'd3);
      one_op("R2 k2", {16'h1235, 16'hFFFF, 16'h0003, 16'hABCD},
                      {16'h0100, 16'h0000, 16'h0000, 16'h0000}, 1'b1, 2'd2);
   endtask

   task automatic t_sat;
      // R3: shift overflow and add overflow in both directions
      one_op("R3 left", {16'h5000, 16'h8000, 16'h4000, 16'hC000},
                        {16'h8000, 16'h0000, 16'h0000, 16'hFFFF}, 1'b0, 2'd3);
      check("R3 shift-ovf", out_data[63:48], 16'h7FFF);
      check("R3 neg-min",   out_data[47:32], 16'h8000);
      one_op("R3 right", {16'h7FFF, 16'h8000, 16'h0000, 16'h0000},
                         {16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000}, 1'b1, 2'd1);
      check("R3 right-hi", out_data[63:48], 16'h7FFF);
      check("R3 right-lo", out_data[47:32], 16'h8000);
   endtask

   task automatic t_iso;
      // R4: ones above a right-shifted lane; saturating lane beside small ones
      one_op("R4 right", {16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001}, '0, 1'b1, 2'd3);
      check("R4 no-leak-down", out_data[15:0], 16'h0000);
      one_op("R4 left", {16'h0001, 16'h7FFF, 16'h0000, 16'hE000}, '0, 1'b0, 2'd3);
      check("R4 no-leak-up", out_data[63:48], 16'h0008);
      check("R4 next-lane", out_data[31:16], 16'h0000);
   endtask

   task automatic t_amt0;
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [W-1:0] r1;
      ra = {16'h0F0F, 16'hFFF3, 16'h4001, 16'h0005};
      rb = {16'h0001, 16'h0002, 16'h0003, 16'h0004};
      // R5: amount 0 gives the same as amount 1
      one_op("R5 left ref", ra, rb, 1'b0, 2'd1);
      r1 = out_data;
      one_op("R5 left", ra, rb, 1'b0, 2'd0);
      check("R5 left eq", out_data, r1);
      one_op("R5 right", ra, rb, 1'b1, 2'd0);
      check("R5 right lit", out_data[15:0], 16'h0006);
   endtask

   task automatic t_timing;
      logic [W-1:0] keep;
      // R6: back-to-back strobes
      @(negedge clk);
      launch({4{16'h0010}}, {4{16'h0001}}, 1'b0, 2'd1);
      @(negedge clk);
      check_bit("R6 v1", out_valid, 1'b1);
      check("R6 d1", out_data, {4{16'h0021}});
      launch({4{16'h0010}}, {4{16'h0001}}, 1'b1, 2'd2);
      @(negedge clk);
      in_valid = 1'b0;
      check_bit("R6 v2", out_valid, 1'b1);
      check("R6 d2", out_data, {4{16'h0005}});
      keep = out_data;
      // R7: inputs move with strobe low
      in_a = {4{16'h7777}}; in_b = {4{16'h1234}}; in_dir = 1'b0; in_amt = 2'd3;
      @(negedge clk);
      check_bit("R6 idle", out_valid, 1'b0);
      check("R7 hold1", out_data, keep);
      in_a = {4{16'h8000}}; in_dir = 1'b1;
      @(negedge clk);
      check("R7 hold2", out_data, keep);
   endtask

   task automatic t_reset_mid;
      @(negedge clk);
      launch({4{16'h0100}}, '0, 1'b0, 2'd1);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      // R8
      check_bit("R8 mid valid", out_valid, 1'b0);
      check("R8 mid data", out_data, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_left();
      t_right();
      t_sat();
      t_iso();
      t_amt0();
      t_timing();
      t_reset_mid();
      repeat (2) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule